// File: doc/BRIEF.md
# Write-Only Serial Configuration Receiver

This block is a slave on a two-wire serial bus (one clock line, one open-drain data line) that only ever receives. It conditions both lines with a synchronizer and a glitch filter in the system clock domain, recognises start and stop conditions, collects bytes most significant bit first and pulls the data line low to acknowledge each accepted byte. Nothing is ever read back from it.

A transfer to this block is a fixed block of ten bytes: the device address, two protocol bytes whose values are consumed and discarded, and seven payload bytes. Payload bytes are held in a staging copy and move into the live configuration bank only when a stop ends a complete, correctly addressed frame. Until written, the bank holds parameterised power-on values, so a system that never touches the bus still gets a working configuration. The live bank drives the output enables and mode controls elsewhere on the chip.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, `cfg_bytes` equals the default value (payload byte k lives in `cfg_bytes[8k+7:8k]`, default bytes 0 to 5 are 0xFF and byte 6 is 0x00) and `sda_pull` is 0.
- R2: A falling data line while the clock line is high is a start; a rising data line while the clock line is high is a stop; each bit is taken on a rising clock line, most significant bit first, and `sda_pull` is 0 in the cycle after a start or stop is recognised.
- R3: A frame of exactly ten bytes whose first byte is 0xD2 (binary 11010010), ended by a stop, loads payload byte k (the (k+4)-th byte on the bus) into byte k of `cfg_bytes` in one step after the stop.
- R4: For each of the ten bytes of a frame addressed to 0xD2, `sda_pull` goes high after the clock line falls following the eighth bit and drops after the next clock fall, so the data line is low throughout the acknowledge clock pulse; `sda_pull` only changes while the clock line is low.
- R5: If the first byte is not 0xD2, no byte of the frame is acknowledged and `cfg_bytes` is unchanged.
- R6: The values of the second and third bytes have no effect on what is loaded.
- R7: A frame ended by a stop after fewer than ten bytes, or cut short by a new start, changes no register; `cfg_bytes` changes only in the cycle after a commit.
- R8: A byte beyond the tenth is not acknowledged and the whole frame is discarded at the following stop.
- R9: Bits cleared in the write mask (by default the upper four bits of payload byte 6) keep their default value whatever is written.
- R10: A pulse shorter than FILT_LEN system clocks (default 4) on either line is ignored: it adds no bit and forms no start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample both bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin (wired with the pull-down) |
| sda_pull | output | 1 | 1 drives the data line low for an acknowledge |
| cfg_bytes | output | 56 | Live configuration bank, payload byte k in bits 8k+7:8k |

## Verification
A bit counter or byte counter that drifts shows first at the acknowledge: the pull-down appears a clock pulse early or late, or on a byte where it must not, and the scoreboard sees that within the same byte. A wrong address decision or lost staging data only reaches the ports at the stop, where the register bank either changes when it must not or takes a value other than the modelled one about ten system clocks later. Glitch and repeated-start cases are built so that a filter or condition detector fault misaligns the frame and so surfaces in the same two places.

// File: rtl/cfgrx_pkg.sv
// Package: shared types for the serial configuration receiver.
// Assumes: one frame engine per receiver; state encoding is local to it.
package cfgrx_pkg;

    // Frame engine states
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,   // waiting for a start
        RX_BITS = 2'd1,   // shifting in bits of the current byte
        RX_ACK  = 2'd2,   // acknowledge slot after a complete byte
        RX_SKIP = 2'd3    // frame rejected, wait for next start
    } rx_state_t;

    // Index of the two conditioned lines inside a 2-bit vector
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

endpackage

// File: rtl/line_filter.sv
// Module: line_filter
// Brings one asynchronous bus line into the clk domain with a two-flop
// synchronizer, then passes a level change only after it has been stable
// for FILT_LEN consecutive cycles. Assumes the idle line level is high.
module line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic             sync1;
    logic             sync2;
    logic [CNT_W-1:0] run_cnt;

    // Two-flop synchronizer, reset to the idle-high level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    // Stability counter: accept a new level after FILT_LEN equal samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt    <= 1'b1;
            run_cnt <= '0;
        end else if (sync2 == filt) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_W'(FILT_LEN - 1)) begin
            filt    <= sync2;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bus_cond_detect.sv
// Module: bus_cond_detect
// Compares the filtered lines with their value one cycle earlier and flags
// clock edges and start/stop conditions as single-cycle pulses.
// Assumes inputs are already synchronous and glitch-free.
module bus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Previous-cycle copy of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Edge and condition decode; data edges count only with clock held high
    always_comb begin
        scl_rise  = !scl_q && scl_f;
        scl_fall  = scl_q && !scl_f;
        start_det = scl_q && scl_f && sda_q && !sda_f;
        stop_det  = scl_q && scl_f && !sda_q && sda_f;
    end
endmodule

// File: rtl/frame_rx.sv
// Module: frame_rx
// Byte assembly, address check, acknowledge generation and staging of the
// payload for one fixed-length write frame. Raises commit for one cycle
// when a stop closes a complete frame addressed to DEV_ADDR.
// Assumes start/stop/edge pulses from bus_cond_detect.
module frame_rx
    import cfgrx_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR   = 8'hD2,
    parameter int         SKIP_BYTES = 2,
    parameter int         NUM_DATA   = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic                  sda_f,
    output logic                  sda_pull,
    output logic                  commit,
    output logic [8*NUM_DATA-1:0] shadow
);
    localparam int FRAME_BYTES = 1 + SKIP_BYTES + NUM_DATA;
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1);
    localparam int FIRST_DATA  = 1 + SKIP_BYTES;

    rx_state_t        st;
    logic [2:0]       bit_cnt;
    logic [6:0]       shreg;
    logic [CNT_W-1:0] byte_cnt;
    logic             addr_ok;
    logic [7:0]       byte_val;
    logic             frame_full;
    logic             frame_good;

    // Byte being completed by the current clock rise, and frame status
    always_comb begin
        byte_val   = {shreg, sda_f};
        frame_full = (byte_cnt == CNT_W'(FRAME_BYTES));
        frame_good = addr_ok && frame_full && (st == RX_BITS) && (bit_cnt <= 3'd1);
    end

    // Frame sequencing: conditions first, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RX_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_cnt <= '0;
            addr_ok  <= 1'b0;
            sda_pull <= 1'b0;
            commit   <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (start_det) begin
                st       <= RX_BITS;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                addr_ok  <= 1'b0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                commit   <= frame_good;
                st       <= RX_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (st)
                    RX_BITS: begin
                        if (scl_rise) begin
                            shreg   <= byte_val[6:0];
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) begin
                                bit_cnt <= '0;
                                if (frame_full) begin
                                    st <= RX_SKIP;
                                end else if (byte_cnt == '0) begin
                                    addr_ok  <= (byte_val == DEV_ADDR);
                                    st       <= (byte_val == DEV_ADDR) ? RX_ACK : RX_SKIP;
                                    byte_cnt <= byte_cnt + 1'b1;
                                end else begin
                                    st       <= RX_ACK;
                                    byte_cnt <= byte_cnt + 1'b1;
                                end
                            end
                        end
                    end
                    RX_ACK: begin
                        if (scl_fall) begin
                            if (!sda_pull) begin
                                sda_pull <= 1'b1;
                            end else begin
                                sda_pull <= 1'b0;
                                st       <= RX_BITS;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

    // Payload staging: each complete data byte lands in its own slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (st == RX_BITS && scl_rise && bit_cnt == 3'd7
                     && !start_det && !stop_det) begin
            for (int k = 0; k < NUM_DATA; k++) begin
                if (byte_cnt == CNT_W'(k + FIRST_DATA)) begin
                    shadow[8*k +: 8] <= byte_val;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_bank.sv
// Module: cfg_bank
// Live configuration registers. Each byte resets to its default and takes
// the staged value on commit, except for bits cleared in WMASK, which
// always keep their default. Assumes commit is a single-cycle pulse.
module cfg_bank #(
    parameter int                     NUM_DATA = 7,
    parameter logic [8*NUM_DATA-1:0]  DEFAULTS = '0,
    parameter logic [8*NUM_DATA-1:0]  WMASK    = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [8*NUM_DATA-1:0] shadow,
    output logic [8*NUM_DATA-1:0] live
);
    genvar g;
    generate
        for (g = 0; g < NUM_DATA; g++) begin : g_byte
            localparam logic [7:0] DEF_B = DEFAULTS[8*g +: 8];
            localparam logic [7:0] MSK_B = WMASK[8*g +: 8];
            logic [7:0] r;

            // One register byte: default on reset, masked load on commit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r <= DEF_B;
                end else if (commit) begin
                    r <= (DEF_B & ~MSK_B) | (shadow[8*g +: 8] & MSK_B);
                end
            end

            assign live[8*g +: 8] = r;
        end
    endgenerate
endmodule

// File: rtl/cfg_serial_rx.sv
// Module: cfg_serial_rx (top)
// Write-only two-wire configuration receiver: line conditioning, condition
// detection, frame engine and live register bank. sda_pull must drive an
// open-drain pad; sda_in sees the resulting wired line.
module cfg_serial_rx
    import cfgrx_pkg::*;
#(
    parameter int         FILT_LEN   = 4,
    parameter logic [7:0] DEV_ADDR   = 8'hD2,
    parameter int         SKIP_BYTES = 2,
    parameter int         NUM_DATA   = 7,
    parameter logic [8*NUM_DATA-1:0] CFG_DEFAULT = 56'h00_FF_FF_FF_FF_FF_FF,
    parameter logic [8*NUM_DATA-1:0] CFG_WMASK   = 56'h0F_FF_FF_FF_FF_FF_FF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull,
    output logic [8*NUM_DATA-1:0] cfg_bytes
);
    localparam int CFG_W = 8 * NUM_DATA;

    logic [1:0]       raw_lines;
    logic [1:0]       filt_lines;
    logic             scl_f;
    logic             sda_f;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             commit;
    logic [CFG_W-1:0] shadow;

    assign raw_lines[LINE_SCL] = scl_in;
    assign raw_lines[LINE_SDA] = sda_in;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_line
            line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .raw   (raw_lines[g]),
                .filt  (filt_lines[g])
            );
        end
    endgenerate

    assign scl_f = filt_lines[LINE_SCL];
    assign sda_f = filt_lines[LINE_SDA];

    bus_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    frame_rx #(
        .DEV_ADDR   (DEV_ADDR),
        .SKIP_BYTES (SKIP_BYTES),
        .NUM_DATA   (NUM_DATA)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_f     (sda_f),
        .sda_pull  (sda_pull),
        .commit    (commit),
        .shadow    (shadow)
    );

    cfg_bank #(
        .NUM_DATA (NUM_DATA),
        .DEFAULTS (CFG_DEFAULT),
        .WMASK    (CFG_WMASK)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .shadow (shadow),
        .live   (cfg_bytes)
    );
endmodule

// File: rtl/cfgrx_checks.sv
// Module: cfgrx_checks
// Protocol properties for cfg_serial_rx, attached with bind below.
// Assumes synchronous active-low reset on rst_n.
module cfgrx_checks #(
    parameter int CFG_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             start_det,
    input logic             stop_det,
    input logic             commit,
    input logic             sda_pull,
    input logic [CFG_W-1:0] cfg_bytes
);
    AST_BANK_HOLDS_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_bytes)); // R7

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_det)); // R3

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R3

    AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_f); // R4

    AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_f); // R4

    AST_RELEASE_AT_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_pull); // R2
endmodule

bind cfg_serial_rx cfgrx_checks #(.CFG_W(CFG_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .start_det (start_det),
    .stop_det  (stop_det),
    .commit    (commit),
    .sda_pull  (sda_pull),
    .cfg_bytes (cfg_bytes)
);

// File: tb/cfg_serial_rx_test.sv
// Bench for cfg_serial_rx: a bus driver plays frames and pushes the expected
// register bank into a scoreboard queue; a monitor pops and compares.
module cfg_serial_rx_test;
    localparam int          Q     = 20;   // system clocks per bus half-period
    localparam logic [55:0] DEF   = 56'h00_FF_FF_FF_FF_FF_FF;
    localparam logic [55:0] MASK  = 56'h0F_FF_FF_FF_FF_FF_FF;
    localparam logic [7:0]  ADDR  = 8'hD2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scl_m;
    logic        sda_m;
    logic        sda_line;
    logic        sda_pull;
    logic [55:0] cfg;

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;
    logic [55:0] model;
    logic [55:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    assign sda_line = sda_m & ~sda_pull;

    cfg_serial_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_pull  (sda_pull),
        .cfg_bytes (cfg)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    // One byte MSB first plus acknowledge slot; optional short glitches
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag, input bit glitch);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch && i == 7) begin
                repeat (5) @(negedge clk);
                scl_m = 1'b1; repeat (2) @(negedge clk);
                scl_m = 1'b0; repeat (Q - 7) @(negedge clk);
            end else begin
                half();
            end
            scl_m = 1'b1;
            if (glitch && b[i]) begin
                repeat (5) @(negedge clk);
                sda_m = 1'b0; repeat (2) @(negedge clk);
                sda_m = 1'b1; repeat (Q - 7) @(negedge clk);
            end else begin
                half();
            end
            scl_m = 1'b0;
        end
        sda_m = 1'b1;
        half();
        chk(sda_pull == exp_ack, {tag, " ack before clock"}, 64'(sda_pull), 64'(exp_ack));
        scl_m = 1'b1;
        half();
        chk(sda_line == !exp_ack, {tag, " line during ack clock"}, 64'(sda_line), 64'(!exp_ack));
        scl_m = 1'b0;
    endtask

    function automatic logic [7:0] byte_at(input int k, input logic [7:0] a, input logic [7:0] c1,
                                           input logic [7:0] c2, input logic [55:0] d);
        if (k == 0) return a;
        if (k == 1) return c1;
        if (k == 2) return c2;
        if (k < 10) return d[8*(k-3) +: 8];
        return 8'h5A;
    endfunction

    // Whole frame: start, nbytes, stop, then expected bank into the scoreboard
    task automatic frame(input logic [7:0] a, input logic [7:0] c1, input logic [7:0] c2,
                         input logic [55:0] d, input int nbytes, input string tag, input bit glitch);
        bus_start();
        for (int k = 0; k < nbytes; k++) begin
            send_byte(byte_at(k, a, c1, c2, d), (a == ADDR) && k < 10,
                      (k >= 10) ? "R8" : ((a == ADDR) ? "R4" : "R5"), glitch && k >= 3);
        end
        bus_stop();
        if (a == ADDR && nbytes == 10) model = (DEF & ~MASK) | (d & MASK);
        repeat (10) @(negedge clk);
        exp_q.push_back(model);
        tag_q.push_back(tag);
        half();
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [55:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cfg == e, t, 64'(cfg), 64'(e));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Driver
    initial begin
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        model = DEF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cfg == DEF, "R1 reset bank", 64'(cfg), 64'(DEF));
        chk(sda_pull == 1'b0, "R1 reset pull", 64'(sda_pull), 64'h0);

        // R2 R3 R9: valid frame, bit order and reserved nibble
        frame(ADDR, 8'h00, 8'h07, 56'hF1_23_45_67_89_AB_CD, 10, "R2 R3 R9 valid load", 1'b0);
        // R5: addresses off by one bit
        frame(8'hD3, 8'h00, 8'h07, 56'h00_00_00_00_00_00_00, 10, "R5 wrong address lsb", 1'b0);
        frame(8'h52, 8'h00, 8'h07, 56'h00_00_00_00_00_00_00, 10, "R5 wrong address msb", 1'b0);
        // R6: different protocol byte values
        frame(ADDR, 8'hFF, 8'h00, 56'h0E_10_20_30_40_50_60, 10, "R6 ignored protocol bytes", 1'b0);
        // R7: early stop
        frame(ADDR, 8'h00, 8'h07, 56'h05_5A_5A_5A_5A_5A_5A, 6, "R7 early stop", 1'b0);
        // R7: partial frame cut by a repeated start, then a full frame
        bus_start();
        for (int k = 0; k < 5; k++) send_byte(byte_at(k, ADDR, 8'h00, 8'h07, 56'h0), 1'b1, "R4", 1'b0);
        frame(ADDR, 8'h00, 8'h07, 56'h03_11_22_33_44_55_66, 10, "R7 repeated start restart", 1'b0);
        // R8: eleven bytes
        frame(ADDR, 8'h00, 8'h07, 56'h00_00_00_00_00_00_00, 11, "R8 overlong frame", 1'b0);
        // R10: glitches on both lines during data bytes
        frame(ADDR, 8'h00, 8'h07, 56'h8A_9B_AC_BD_CE_DF_E0, 10, "R10 glitch filter", 1'b1);
        // R3 R9: extreme patterns
        frame(ADDR, 8'h00, 8'h07, 56'h00_00_00_00_00_00_00, 10, "R3 all zero load", 1'b0);
        frame(ADDR, 8'h00, 8'h07, 56'hFF_FF_FF_FF_FF_FF_FF, 10, "R3 R9 all one load", 1'b0);

        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R3 scoreboard drained", 64'(exp_q.size()), 64'h0);
        chk(sda_pull == 1'b0, "R2 idle pull", 64'(sda_pull), 64'h0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule